// File: doc/BRIEF.md
# Tag Memory Protection and RF Access Policy Unit

This block holds the protection state of a dual-interface tag memory (a wired host port and a radio port) and decides, for every radio-side access, whether it may proceed. The host side writes two control words: a protection word, which carries the per-bank lock pairs, the user-memory block permalock bits and the kill flag, and a control word, which carries the per-port radio disables, the DC-present enable and the block-permalock command enable. Radio-side commands can set the kill flag and permalock user blocks. All permission decisions are combinational from the registered state, so a change takes effect from the first request after the clock edge that stores it.

For each radio request the unit reports exactly one outcome: allowed, denied by protection, rejected with a format error, or muted (no response). The radio link is accepted only when the tag is not killed, is not inhibited by DC presence, and at least one active port is enabled. The host side is never subject to the lock pairs.

Top module: `nvm_guard`

## Requirements
- R1: After reset every stored bit is 0 (lock pairs, block locks, kill, port disables, DC enable, permalock command enable); with DC present and a port active, the link is then refused.
- R2: Bank code 2 (EPC) and 3 (user) use the pair at bits [2b+1:2b] of the lock field (bit 2b+1 = password bit, bit 2b = permalock bit) for writes only: 00 and 01 allow in any state, 10 allows only when secured, 11 never allows. Reads of these banks are not governed by the pair.
- R3: Bank code 0 (kill password) and 1 (access password) apply the same pair decode to reads and to writes.
- R4: A host protection write stores bits [7:0] as lock pairs and bit 13 as kill, replacing the previous values; it can clear kill.
- R5: In the same write, bits [12:8] carry block locks 0..4: block 0 takes the new value, blocks 1..4 are OR-merged with their current values and never clear.
- R6: A radio write to user bank word pointer p touches block p/32 (block 4 covers words 128..135); a write into a locked block is denied, a read of it is allowed, and any user access with p >= 136 is denied.
- R7: A radio permalock command ORs its mask into the block locks only when control bit 3 (permalock enable) is 1 and the link is accepted; otherwise the block locks stay unchanged.
- R8: A radio kill command sets kill when the link is accepted.
- R9: Link priority: kill refuses the link; otherwise DC present with control bit 2 (DC enable) at 0 refuses it; otherwise port k is enabled when it is active and control bit k (port disable) is 0, and the link is accepted if any port is enabled.
- R10: For radio writes, a count of 0 gives no response, a count above 2 or a count of 2 with an odd pointer gives a format error; counts 1 and 2 with even pointer proceed to the protection check. Reads ignore the count.
- R11: Each request asserts exactly one of allow, deny, format error, mute; a refused link mutes every request.
- R12: A host write (either word) in the same cycle as a radio kill or permalock command takes precedence and the radio update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_wr_i | input | 1 | Host protection word write strobe |
| prot_wdata_i | input | 14 | Lock pairs [7:0], block locks [12:8], kill [13] |
| ctl_wr_i | input | 1 | Host control word write strobe |
| ctl_wdata_i | input | 4 | Port disables [1:0], DC enable [2], permalock enable [3] |
| rf_kill_i | input | 1 | Radio kill command |
| rf_bpl_i | input | 1 | Radio block permalock command |
| rf_bpl_mask_i | input | 5 | Blocks to permalock |
| dc_present_i | input | 1 | DC supply present |
| port_act_i | input | 2 | Radio port activity |
| rf_req_i | input | 1 | Radio access request valid |
| rf_bank_i | input | 2 | Target bank code |
| rf_write_i | input | 1 | 1 = write, 0 = read |
| rf_secured_i | input | 1 | Requester in secured state |
| rf_ptr_i | input | 8 | Word pointer |
| rf_cnt_i | input | 3 | Word count |
| lock_o | output | 8 | Stored lock pairs |
| blk_lock_o | output | 5 | Stored block locks |
| kill_o | output | 1 | Stored kill flag |
| ctl_o | output | 4 | Stored control word |
| port_en_o | output | 2 | Per-port radio enable |
| link_ok_o | output | 1 | Radio link accepted |
| rf_allow_o | output | 1 | Request allowed |
| rf_deny_o | output | 1 | Request denied by protection |
| rf_fmt_err_o | output | 1 | Request format error |
| rf_mute_o | output | 1 | No response |

## Verification
The bench builds the unit with its defaults: two radio ports, five blocks of 32 words with an 8-word last block, an 8-bit pointer and a 3-bit count. The 3-bit count reaches values far above two, and pointers drawn up to 159 cross the end of user memory at word 136 and every block boundary, including the short last block. Two ports make the per-port disable and activity combinations, and the "any enabled port" rule, fully reachable alongside the kill and DC levels.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
  localparam int NBANK  = 4;
  localparam int BANK_W = 2;

  typedef enum logic [BANK_W-1:0] {
    BANK_KPWD = 2'd0,
    BANK_APWD = 2'd1,
    BANK_EPC  = 2'd2,
    BANK_USER = 2'd3
  } bank_e;

  typedef struct packed {
    logic allow;
    logic deny;
    logic fmt;
    logic mute;
  } outcome_t;
endpackage

// File: rtl/nvm_guard_regs.sv
module nvm_guard_regs #(
  parameter int NBANK = 4,
  parameter int NBLK  = 5,
  parameter int NPORT = 2,
  localparam int LOCK_W = 2 * NBANK,
  localparam int PROT_W = LOCK_W + NBLK + 1,
  localparam int CTL_W  = NPORT + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_wr_i,
  input  logic [PROT_W-1:0] prot_wdata_i,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              rf_ok_i,
  input  logic              rf_kill_i,
  input  logic              rf_bpl_i,
  input  logic [NBLK-1:0]   rf_bpl_mask_i,
  output logic [LOCK_W-1:0] lock_q_o,
  output logic [NBLK-1:0]   blk_q_o,
  output logic              kill_q_o,
  output logic [CTL_W-1:0]  ctl_q_o
);
  localparam int BLK_LSB  = LOCK_W;
  localparam int KILL_BIT = LOCK_W + NBLK;
  localparam int BPL_BIT  = NPORT + 1;

  logic [NBLK-1:0] blk_new;
  logic            host_wr;
  logic            bpl_take;

  assign host_wr  = prot_wr_i | ctl_wr_i;
  assign bpl_take = rf_bpl_i & rf_ok_i & ctl_q_o[BPL_BIT] & ~host_wr;

  // block 0 follows the host, the rest only accumulate
  assign blk_new = {blk_q_o[NBLK-1:1] | prot_wdata_i[BLK_LSB+1 +: NBLK-1],
                    prot_wdata_i[BLK_LSB]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q_o <= '0;
      blk_q_o  <= '0;
      kill_q_o <= 1'b0;
      ctl_q_o  <= '0;
    end else begin
      if (prot_wr_i) begin
        lock_q_o <= prot_wdata_i[LOCK_W-1:0];
        blk_q_o  <= blk_new;
        kill_q_o <= prot_wdata_i[KILL_BIT];
      end
      if (ctl_wr_i) ctl_q_o <= ctl_wdata_i;
      if (!host_wr) begin
        if (rf_kill_i && rf_ok_i) kill_q_o <= 1'b1;
        if (bpl_take) blk_q_o <= blk_q_o | rf_bpl_mask_i;
      end
    end
  end

  generate
    for (genvar b = 1; b < NBLK; b++) begin : g_sticky
      p_blk_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blk_q_o[b] |=> blk_q_o[b]);
    end
  endgenerate

  p_bpl_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_bpl_i && !ctl_q_o[BPL_BIT] && !host_wr) |=> $stable(blk_q_o));

  p_kill_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_kill_i && rf_ok_i && !host_wr) |=> kill_q_o);

  p_host_first_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_wr_i && !prot_wdata_i[KILL_BIT]) |=> !kill_q_o);
endmodule

// File: rtl/nvm_guard_lock.sv
module nvm_guard_lock #(
  parameter int NBANK = 4,
  localparam int LOCK_W = 2 * NBANK
) (
  input  logic [LOCK_W-1:0] lock_i,
  input  logic              secured_i,
  output logic [NBANK-1:0]  pass_o
);
  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [1:0] pair;
      assign pair = lock_i[2*b +: 2];
      // pwd bit clear: open; pwd set + perma clear: secured only; both set: never
      assign pass_o[b] = ~pair[1] | (secured_i & ~pair[0]);
    end
  endgenerate
endmodule

// File: rtl/nvm_guard_link.sv
module nvm_guard_link #(
  parameter int NPORT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kill_i,
  input  logic             dc_present_i,
  input  logic             dc_en_i,
  input  logic [NPORT-1:0] port_dis_i,
  input  logic [NPORT-1:0] port_act_i,
  output logic [NPORT-1:0] port_en_o,
  output logic             link_ok_o
);
  logic inhibit;

  assign inhibit = kill_i | (dc_present_i & ~dc_en_i);

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign port_en_o[p] = ~inhibit & ~port_dis_i[p] & port_act_i[p];
    end
  endgenerate

  assign link_ok_o = |port_en_o;

  p_kill_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |-> !link_ok_o);

  p_dc_inhibit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_present_i && !dc_en_i) |-> (port_en_o == '0));
endmodule

// File: rtl/nvm_guard.sv
module nvm_guard
  import nvm_guard_pkg::*;
#(
  parameter int NPORT      = 2,
  parameter int NBLK       = 5,
  parameter int BLK_WORDS  = 32,
  parameter int LAST_WORDS = 8,
  parameter int PTR_W      = 8,
  parameter int CNT_W      = 3,
  localparam int LOCK_W = 2 * NBANK,
  localparam int PROT_W = LOCK_W + NBLK + 1,
  localparam int CTL_W  = NPORT + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_wr_i,
  input  logic [PROT_W-1:0] prot_wdata_i,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              rf_kill_i,
  input  logic              rf_bpl_i,
  input  logic [NBLK-1:0]   rf_bpl_mask_i,
  input  logic              dc_present_i,
  input  logic [NPORT-1:0]  port_act_i,
  input  logic              rf_req_i,
  input  logic [BANK_W-1:0] rf_bank_i,
  input  logic              rf_write_i,
  input  logic              rf_secured_i,
  input  logic [PTR_W-1:0]  rf_ptr_i,
  input  logic [CNT_W-1:0]  rf_cnt_i,
  output logic [LOCK_W-1:0] lock_o,
  output logic [NBLK-1:0]   blk_lock_o,
  output logic              kill_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [NPORT-1:0]  port_en_o,
  output logic              link_ok_o,
  output logic              rf_allow_o,
  output logic              rf_deny_o,
  output logic              rf_fmt_err_o,
  output logic              rf_mute_o
);
  localparam int USER_WORDS = (NBLK - 1) * BLK_WORDS + LAST_WORDS;

  logic [NBANK-1:0] pass;
  logic             is_pwd, is_user, lock_ok, blk_hit, range_ok;
  logic             no_resp, bad_fmt;
  outcome_t         res;

  nvm_guard_regs #(.NBANK(NBANK), .NBLK(NBLK), .NPORT(NPORT)) u_regs (
    .clk_i, .rst_ni,
    .prot_wr_i, .prot_wdata_i, .ctl_wr_i, .ctl_wdata_i,
    .rf_ok_i(link_ok_o), .rf_kill_i, .rf_bpl_i, .rf_bpl_mask_i,
    .lock_q_o(lock_o), .blk_q_o(blk_lock_o), .kill_q_o(kill_o), .ctl_q_o(ctl_o)
  );

  nvm_guard_link #(.NPORT(NPORT)) u_link (
    .clk_i, .rst_ni,
    .kill_i(kill_o), .dc_present_i, .dc_en_i(ctl_o[NPORT]),
    .port_dis_i(ctl_o[NPORT-1:0]), .port_act_i,
    .port_en_o, .link_ok_o
  );

  nvm_guard_lock #(.NBANK(NBANK)) u_lock (
    .lock_i(lock_o), .secured_i(rf_secured_i), .pass_o(pass)
  );

  assign is_pwd   = (rf_bank_i == BANK_KPWD) || (rf_bank_i == BANK_APWD);
  assign is_user  = (rf_bank_i == BANK_USER);
  assign lock_ok  = ~(is_pwd | rf_write_i) | pass[rf_bank_i];
  assign range_ok = ~is_user | (int'(rf_ptr_i) < USER_WORDS);

  always_comb begin
    blk_hit = 1'b0;
    for (int b = 0; b < NBLK; b++) begin
      if (blk_lock_o[b] && int'(rf_ptr_i) >= b * BLK_WORDS &&
          int'(rf_ptr_i) < (b + 1) * BLK_WORDS)
        blk_hit = 1'b1;
    end
  end

  assign no_resp = ~link_ok_o | (rf_write_i & (rf_cnt_i == '0));
  assign bad_fmt = rf_write_i & ((int'(rf_cnt_i) > 2) |
                                 ((int'(rf_cnt_i) == 2) & rf_ptr_i[0]));

  always_comb begin
    res = '0;
    if (rf_req_i) begin
      if (no_resp)                                          res.mute  = 1'b1;
      else if (bad_fmt)                                     res.fmt   = 1'b1;
      else if (!lock_ok || !range_ok ||
               (is_user && rf_write_i && blk_hit))          res.deny  = 1'b1;
      else                                                  res.allow = 1'b1;
    end
  end

  assign rf_allow_o   = res.allow;
  assign rf_deny_o    = res.deny;
  assign rf_fmt_err_o = res.fmt;
  assign rf_mute_o    = res.mute;

  p_one_outcome_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_req_i |-> $onehot({rf_allow_o, rf_deny_o, rf_fmt_err_o, rf_mute_o}));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rf_req_i |-> !(rf_allow_o || rf_deny_o || rf_fmt_err_o || rf_mute_o));

  p_no_link_mute_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_req_i && !link_ok_o) |-> rf_mute_o);

  p_locked_blk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_req_i && is_user && rf_write_i && blk_hit) |-> !rf_allow_o);
endmodule

// File: tb/test_nvm_guard.sv
module test_nvm_guard;
  logic        clk = 0, rst_n = 0;
  logic        prot_wr = 0, ctl_wr = 0, rf_kill = 0, rf_bpl = 0;
  logic [13:0] prot_wd = 0;
  logic [3:0]  ctl_wd = 0;
  logic [4:0]  bpl_mask = 0;
  logic        dc = 0, req = 0, wr = 0, sec = 0;
  logic [1:0]  act = 0, bank = 0;
  logic [7:0]  ptr = 0;
  logic [2:0]  cnt = 0;
  logic [7:0]  lock_o;
  logic [4:0]  blk_o;
  logic        kill_o, link_o, allow, deny, fmt, mute;
  logic [3:0]  ctl_o;
  logic [1:0]  pen_o;

  logic [7:0] m_lock = 0;
  logic [4:0] m_blk = 0;
  logic       m_kill = 0;
  logic [3:0] m_ctl = 0;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  nvm_guard i_nvm_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .prot_wr_i(prot_wr), .prot_wdata_i(prot_wd), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd),
    .rf_kill_i(rf_kill), .rf_bpl_i(rf_bpl), .rf_bpl_mask_i(bpl_mask),
    .dc_present_i(dc), .port_act_i(act),
    .rf_req_i(req), .rf_bank_i(bank), .rf_write_i(wr), .rf_secured_i(sec),
    .rf_ptr_i(ptr), .rf_cnt_i(cnt),
    .lock_o(lock_o), .blk_lock_o(blk_o), .kill_o(kill_o), .ctl_o(ctl_o),
    .port_en_o(pen_o), .link_ok_o(link_o),
    .rf_allow_o(allow), .rf_deny_o(deny), .rf_fmt_err_o(fmt), .rf_mute_o(mute)
  );

  task automatic chk(input string req_s, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req_s, act_v, exp_v);
    end
  endtask

  function automatic logic [1:0] exp_pen();
    logic inh = m_kill | (dc & ~m_ctl[2]);
    return inh ? 2'b00 : (act & ~m_ctl[1:0]);
  endfunction

  // {allow, deny, fmt, mute}
  function automatic logic [3:0] exp_out();
    logic [1:0] pair;
    logic ok;
    int blk;
    if (!req) return 4'b0000;
    if (exp_pen() == 2'b00) return 4'b0001;
    if (wr && cnt == 0) return 4'b0001;
    if (wr && (cnt > 2 || (cnt == 2 && ptr[0]))) return 4'b0010;
    pair = m_lock[2*bank +: 2];
    ok = (pair == 2'b00) || (pair == 2'b01) || (pair == 2'b10 && sec);
    if ((bank < 2 || wr) && !ok) return 4'b0100;
    if (bank == 3) begin
      if (ptr >= 136) return 4'b0100;
      blk = ptr / 32;
      if (wr && m_blk[blk]) return 4'b0100;
    end
    return 4'b1000;
  endfunction

  task automatic model_edge();
    if (prot_wr) begin
      m_lock = prot_wd[7:0];
      m_blk  = {m_blk[4:1] | prot_wd[12:9], prot_wd[8]};
      m_kill = prot_wd[13];
    end
    if (ctl_wr) m_ctl = ctl_wd;
    if (!prot_wr && !ctl_wr && exp_pen() != 2'b00) begin
      if (rf_kill) m_kill = 1'b1;
      if (rf_bpl && m_ctl[3]) m_blk = m_blk | bpl_mask;
    end
  endtask

  // inputs set by caller before negedge+1; checks comb, clocks, checks state
  task automatic step(input string tag);
    #2;
    chk({tag, " R9 port enables"}, 32'(pen_o), 32'(exp_pen()));
    chk({tag, " R11 outcome"}, 32'({allow, deny, fmt, mute}), 32'(exp_out()));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    prot_wr = 0; ctl_wr = 0; rf_kill = 0; rf_bpl = 0;
    chk({tag, " R4 state"}, 32'({lock_o, kill_o, ctl_o}), 32'({m_lock, m_kill, m_ctl}));
    chk({tag, " R5 blocks"}, 32'(blk_o), 32'(m_blk));
  endtask

  task automatic rq(input logic [1:0] b, input logic w, input logic s,
                    input logic [7:0] p, input logic [2:0] c);
    req = 1; bank = b; wr = w; sec = s; ptr = p; cnt = c;
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    repeat (2) @(negedge clk);
    // R1: reset state, DC present inhibits by default
    chk("R1 reset regs", 32'({lock_o, blk_o, kill_o, ctl_o}), 32'd0);
    dc = 1; act = 2'b11; #2;
    chk("R1 default DC inhibit", 32'(link_o), 32'd0);
    rst_n = 1;
    @(negedge clk);
    dc = 0; rq(3, 1, 0, 8'd4, 3'd1);
    step("R1 open write");
    // R9: per-port disable, DC enable
    ctl_wr = 1; ctl_wd = 4'b0101; rq(2, 0, 0, 0, 1); step("R9 ctl");
    act = 2'b01; dc = 1; step("R9 port0 disabled");
    act = 2'b10; step("R9 dc enabled port1");
    ctl_wr = 1; ctl_wd = 4'b1110; step("R9 bpl enable");
    // R10: count rules
    act = 2'b11; dc = 0;
    rq(3, 1, 0, 8'd5, 3'd0); step("R10 zero count");
    rq(3, 1, 0, 8'd5, 3'd2); step("R10 odd pair");
    rq(3, 1, 0, 8'd6, 3'd2); step("R10 even pair");
    rq(3, 1, 0, 8'd6, 3'd3); step("R10 count three");
    rq(3, 0, 0, 8'd6, 3'd7); step("R10 read ignores count");
    // R2/R3 lock decode
    prot_wr = 1; prot_wd = {1'b0, 5'b0, 8'b11_10_01_10};
    rq(1, 0, 0, 0, 1); step("R3 prot");
    rq(0, 0, 0, 0, 1); step("R3 kpwd open state");
    rq(0, 0, 1, 0, 1); step("R3 kpwd secured");
    rq(1, 0, 1, 0, 1); step("R3 apwd perma open");
    rq(2, 1, 1, 0, 1); step("R2 epc secured write");
    rq(2, 0, 0, 0, 1); step("R2 epc read");
    rq(3, 1, 1, 0, 1); step("R2 user never");
    rq(3, 0, 0, 0, 1); step("R2 user read");
    // R5 block merge and R6 block boundaries
    prot_wr = 1; prot_wd = {1'b0, 5'b10011, 8'h00}; step("R5 set");
    prot_wr = 1; prot_wd = {1'b0, 5'b00000, 8'h00}; step("R5 only blk0 clears");
    chk("R5 blk1 held", 32'(blk_o), 32'h12);
    rq(3, 1, 0, 8'd31, 3'd1); step("R6 blk0 edge");
    rq(3, 1, 0, 8'd32, 3'd1); step("R6 blk1 locked");
    rq(3, 0, 0, 8'd32, 3'd1); step("R6 read locked");
    rq(3, 1, 0, 8'd135, 3'd1); step("R6 last word");
    rq(3, 0, 0, 8'd136, 3'd1); step("R6 beyond end");
    // R7 / R12
    rf_bpl = 1; bpl_mask = 5'b00101; rq(2, 0, 0, 0, 1); step("R7 bpl taken");
    chk("R7 blocks", 32'(blk_o), 32'h17);
    ctl_wr = 1; ctl_wd = 4'b0100; step("R7 disable bpl");
    rf_bpl = 1; bpl_mask = 5'b01000; step("R7 bpl ignored");
    chk("R7 unchanged", 32'(blk_o), 32'h17);
    ctl_wr = 1; ctl_wd = 4'b1100; rf_bpl = 1; bpl_mask = 5'b01000; step("R12 bpl dropped");
    chk("R12 unchanged", 32'(blk_o), 32'h17);
    // R8 kill and undo
    rf_kill = 1; step("R8 kill");
    chk("R8 killed", 32'({kill_o, link_o}), 32'b10);
    prot_wr = 1; prot_wd = {1'b0, 5'b0, 8'h00}; step("R4 unkill");
    chk("R4 link back", 32'({kill_o, link_o}), 32'b01);
    prot_wr = 1; prot_wd = 14'h0; rf_kill = 1; step("R12 kill dropped");
    chk("R12 kill", 32'(kill_o), 32'd0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op = 4'($urandom_range(0, 9));
      prot_wr = (op == 0); ctl_wr = (op == 1);
      rf_kill = (op == 2); rf_bpl = (op >= 3 && op <= 4);
      prot_wd = 14'($urandom()) & 14'h1FFF;
      if ($urandom_range(0, 3) == 0) prot_wd[13] = 1'b1;
      ctl_wd = 4'($urandom()); bpl_mask = 5'($urandom());
      dc = 1'($urandom()); act = 2'($urandom());
      rq(2'($urandom()), 1'($urandom()), 1'($urandom()),
         8'($urandom_range(0, 159)), 3'($urandom()));
      req = ($urandom_range(0, 7) != 0);
      step("rand");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule